// File: doc/BRIEF.md
# Fractional Clock Divider (divide by 2.5)

This block derives a slower clock from a fast input clock at a ratio of 2.5 to 1, for example 40 MHz from 100 MHz. It does not depend on any minimum gate delay. Every storage element is a flip-flop clocked on one edge or the other of the input clock.

A modulo-DIV counter runs on the rising edge. It produces a pulse one input cycle wide once every DIV cycles. A copy of that pulse passes through a short chain of rising-edge flip-flops and then one falling-edge flip-flop. The copy therefore trails the original by DIV/2 input cycles, which is a whole number of cycles plus one half. The two pulses are ORed to give the divided clock. A second output carries the same waveform re-sampled on the rising edge, for logic that needs a glitch-free registered signal and can accept edges placed only on whole input cycles.

The parameter DIV must be odd and at least 3. Its default of 5 gives the ratio of 2.5. A synchronous active-low reset clears all state, so both outputs sit low.

Top module: `frac_clk_div`

## Requirements
- R1: In steady operation, successive rising edges of `clk_div` are exactly DIV/2 input periods apart (25 ns for DIV=5 with a 10 ns input period).
- R2: The base pulse is high for one full input cycle, starting at rising edges 5, 10, 15, ... counted from reset release. Edge 1 is the first rising edge sampled with `rst_n` high. The pulse repeats once every DIV rising edges.
- R3: The delayed copy of the base pulse starts at the falling edge that lies (DIV-1)/2 + 1/2 input cycles after the start of each base pulse. It lasts one input cycle.
- R4: `clk_div` is the OR of the base pulse and the delayed copy, and it is low at all other times.
- R5: Each high phase of `clk_div` lasts exactly one input cycle, giving a duty cycle of 2/DIV (40% for DIV=5). The base pulse and the delayed copy never overlap.
- R6: While `rst_n` is low, `clk_div` is low from the second rising edge of the reset, `clk_div_q` is low from the first rising edge of the reset, and the counter and delay stages are cleared.
- R7: After reset release, the first high phase of `clk_div` begins at rising edge DIV, which for the default is within 5 input cycles.
- R8: `clk_div_q` changes only on rising edges of the input clock. After each rising edge it holds the value that `clk_div` had just before that edge.
- R9: Asserting reset in the middle of operation, including during a high phase, restarts the sequence so that it behaves exactly as it does after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | output | 1 | Divided clock, OR of base and delayed pulses |
| clk_div_q | output | 1 | `clk_div` re-sampled on the rising edge of `clk_in` |

## Verification
The case that needs the most care is a reset that arrives while a high phase is in flight. In that case the falling-edge stage can still be high during the half cycle after the counter and the rising stages have already cleared. The bench provokes this with a directed reset during the base pulse and with reset points chosen at random, which often land on either pulse. It judges each half cycle against a model. The model treats the last half-cycle of the delayed pulse as undefined only until the first falling edge inside reset, and it requires a clean restart at edge DIV after release.

// File: rtl/d25_pkg.sv
// Package: shared helper functions for the fractional clock divider.
// Assumes DIV is odd and at least 3.
package d25_pkg;

    // Number of whole rising-edge delay stages for a DIV/2 lag.
    function automatic int rise_stages(input int div);
        return (div - 1) / 2;
    endfunction

    // Counter width needed to hold 0..div-1.
    function automatic int cnt_bits(input int div);
        return (div <= 2) ? 1 : $clog2(div);
    endfunction

endpackage

// File: rtl/d25_modcount.sv
// Module: modulo-DIV counter with a registered one-cycle pulse.
// The pulse is high in exactly the cycle in which the count reads zero.
// Assumes a synchronous active-low reset and DIV >= 2.
module d25_modcount #(
    parameter int DIV = 5,
    parameter int W   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt,
    output logic         pulse
);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    // Count 0..DIV-1 and wrap; raise pulse as the count returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            cnt   <= (cnt == LAST) ? '0 : cnt + W'(1);
            pulse <= (cnt == LAST);
        end
    end

    // R2: the count wraps from the top value straight to zero
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));

    // R2: the pulse is only ever seen together with a zero count
    a_r2_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (cnt == '0));

    // R5: the base pulse is one cycle wide
    a_r5_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R6: reset clears count and pulse
    a_r6_count_clear: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !pulse));

endmodule

// File: rtl/d25_rise_delay.sv
// Module: chain of STAGES rising-edge flip-flops delaying a single bit.
// Assumes STAGES >= 1 and a synchronous active-low reset.
module d25_rise_delay #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First stage samples the input.
                always_ff @(posedge clk) begin
                    if (!rst_n) sh[0] <= 1'b0;
                    else        sh[0] <= din;
                end
            end else begin : g_next
                // Later stages sample the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) sh[gi] <= 1'b0;
                    else        sh[gi] <= sh[gi-1];
                end
            end
        end
    endgenerate

    assign dout = sh[STAGES-1];

    // R6: every stage is cleared by reset
    a_r6_delay_clear: assert property (@(posedge clk)
        !rst_n |=> (sh == '0));

endmodule

// File: rtl/d25_fall_stage.sv
// Module: single falling-edge flip-flop that adds the half-cycle of lag.
// Reset is sampled on the falling edge as well, so it is synchronous to it.
module d25_fall_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q
);
    // Capture the input on the falling edge of the clock.
    always_ff @(negedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= din;
    end

    // R6: a falling edge inside reset clears the stage
    a_r6_fall_clear: assert property (@(negedge clk)
        !rst_n |=> !q);

endmodule

// File: rtl/frac_clk_div.sv
// Module: divides clk_in by DIV/2 (2.5 for the default) by ORing a
// modulo-DIV pulse with a copy delayed by DIV/2 input cycles.
// Assumes DIV odd and >= 3; reset is synchronous and active low.
// clk_div is a combinational OR of two flip-flop outputs; clk_div_q is
// the registered version with edges only on rising input edges.
module frac_clk_div #(
    parameter int DIV = 5
) (
    input  logic clk_in,
    input  logic rst_n,
    output logic clk_div,
    output logic clk_div_q
);
    import d25_pkg::*;

    localparam int H = rise_stages(DIV);
    localparam int W = cnt_bits(DIV);
    localparam logic [W-1:0] LATE_CNT = W'(H);

    logic [W-1:0] cnt;
    logic         base_p;
    logic         late_p;
    logic         half_p;

    d25_modcount #(.DIV(DIV), .W(W)) u_count (
        .clk   (clk_in),
        .rst_n (rst_n),
        .cnt   (cnt),
        .pulse (base_p)
    );

    d25_rise_delay #(.STAGES(H)) u_rise (
        .clk   (clk_in),
        .rst_n (rst_n),
        .din   (base_p),
        .dout  (late_p)
    );

    d25_fall_stage u_fall (
        .clk   (clk_in),
        .rst_n (rst_n),
        .din   (late_p),
        .q     (half_p)
    );

    assign clk_div = base_p | half_p;

    // Re-sample the divided clock on the rising edge.
    always_ff @(posedge clk_in) begin
        if (!rst_n) clk_div_q <= 1'b0;
        else        clk_div_q <= clk_div;
    end

    // R3: the whole-cycle part of the lag lines up with count value H
    a_r3_lag_phase: assert property (@(posedge clk_in) disable iff (!rst_n)
        late_p |-> (cnt == LATE_CNT));

    // R5: base pulse and delayed copy are never high together
    a_r5_no_overlap: assert property (@(posedge clk_in) disable iff (!rst_n)
        !(base_p && half_p));

    // R6: the registered output is low after a reset edge
    a_r6_q_clear: assert property (@(posedge clk_in)
        !rst_n |=> !clk_div_q);

endmodule

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;
    localparam real CLK_PERIOD = 10.0;
    localparam int  DIV = 5;
    localparam int  H   = (DIV - 1) / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_div, clk_div_q;

    int n_chk = 0;
    int n_fail = 0;
    int m = 0;       // rising edges since release
    int rc = 0;      // rising edges inside reset
    int resets = 0;  // number of releases seen
    logic prev_div = 1'b0;
    real  last_rise = -1.0;
    int   run_len = 0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    frac_clk_div #(.DIV(DIV)) i_frac_clk_div (
        .clk_in    (clk),
        .rst_n     (rst_n),
        .clk_div   (clk_div),
        .clk_div_q (clk_div_q)
    );

    function automatic logic base_on(input int e);
        return (e >= DIV) && (e % DIV == 0);
    endfunction
    function automatic logic late_first(input int e);
        return (e >= DIV + H + 1) && ((e - H - 1) % DIV == 0);
    endfunction
    function automatic logic late_second(input int e);
        return (e >= DIV + H) && ((e - H) % DIV == 0);
    endfunction
    function automatic logic exp_second(input int e);
        return base_on(e) | late_second(e);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Edge spacing (R1) and high-phase width (R5), judged per half-cycle sample.
    task automatic shape_check();
        if (rst_n && m > DIV + H + 1) begin
            if (clk_div && !prev_div) begin
                if (last_rise >= 0.0)
                    chk("R1 rise spacing", ($realtime - last_rise) == CLK_PERIOD * DIV / 2.0, 1'b1);
                last_rise = $realtime;
            end
            if (!clk_div && prev_div && run_len > 0)
                chk("R5 high width", run_len == 2, 1'b1);
        end else begin
            last_rise = -1.0;
        end
        run_len = clk_div ? run_len + 1 : 0;
        if (!rst_n || m <= DIV) run_len = 0;
        prev_div = clk_div;
    endtask

    task automatic run_cycle(input logic next_rst);
        logic e;
        @(posedge clk);
        #(CLK_PERIOD / 4.0);
        if (rst_n) begin m++; rc = 0; end
        else begin rc++; m = 0; end
        // first half after the rising edge
        if (!rst_n) begin
            if (rc >= 2) chk("R6 clk_div in reset", clk_div, 1'b0);
            if (rc >= 1) chk("R6 clk_div_q in reset", clk_div_q, 1'b0);
        end else begin
            e = base_on(m) | late_first(m);
            if (base_on(m) && m == DIV && resets > 1) chk("R9 restart pulse", clk_div, 1'b1);
            else if (base_on(m) && m == DIV)          chk("R7 first pulse", clk_div, 1'b1);
            else if (base_on(m))                      chk("R2 base pulse", clk_div, 1'b1);
            else if (late_first(m))                   chk("R3 delayed pulse 2nd half", clk_div, 1'b1);
            else                                      chk("R4 low phase", clk_div, e);
            chk("R8 registered output", clk_div_q, (m >= 1) ? exp_second(m - 1) : 1'b0);
        end
        shape_check();
        @(negedge clk);
        #(CLK_PERIOD / 4.0);
        // second half after the rising edge
        if (!rst_n) begin
            if (rc >= 1) chk("R6 clk_div in reset", clk_div, 1'b0);
            if (rc >= 1) chk("R6 clk_div_q in reset", clk_div_q, 1'b0);
        end else begin
            if (base_on(m))          chk("R2 base pulse", clk_div, 1'b1);
            else if (late_second(m)) chk("R3 delayed pulse start", clk_div, 1'b1);
            else                     chk("R4 low phase", clk_div, 1'b0);
            chk("R8 registered holds", clk_div_q, (m >= 1) ? exp_second(m - 1) : 1'b0);
        end
        shape_check();
        if (next_rst && !rst_n) resets++;
        rst_n = next_rst;
    endtask

    initial begin
        void'($urandom(32'd2024));
        // directed: initial reset, then a long run
        for (int i = 0; i < 5; i++) run_cycle(1'b0);
        for (int i = 0; i < 60; i++) run_cycle(1'b1);
        // directed: reset asserted during the base pulse cycle
        while (!base_on(m + 1)) run_cycle(1'b1);
        run_cycle(1'b0);
        for (int i = 0; i < 3; i++) run_cycle(1'b0);
        for (int i = 0; i < 40; i++) run_cycle(1'b1);
        // directed: reset asserted while the delayed half-cycle is high
        while (!late_second(m + 1)) run_cycle(1'b1);
        run_cycle(1'b0);
        run_cycle(1'b0);
        for (int i = 0; i < 30; i++) run_cycle(1'b1);
        // random run and reset lengths
        for (int k = 0; k < 40; k++) begin
            int rl;
            int hl;
            rl = 3 + int'($urandom_range(60));
            hl = 2 + int'($urandom_range(4));
            for (int i = 0; i < rl; i++) run_cycle(1'b1);
            for (int i = 0; i < hl; i++) run_cycle(1'b0);
        end
        for (int i = 0; i < 30; i++) run_cycle(1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000.0);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule